// File: doc/BRIEF.md
# Parallel SCSI Controller Host Register File

This block is the register window that a host processor sees on a small parallel SCSI bus controller. The host selects one of eight byte locations with a 3-bit address, an active-low chip select and active-low read and write strobes. The block holds the outgoing data byte, the initiator command, the operating mode, the target phase bits and the select-ID byte. It turns these into bus driver enables and returns live snapshots of the bus and of controller status when read.

Several locations behave differently on read and on write. A write to locations 5, 6 or 7 only issues a one-cycle start strobe to the DMA engine. A read of location 7 clears the parity error flag and the interrupt. Each strobe assertion runs through a small access state machine with four states. ACC_IDLE waits for a strobe and moves to ACC_READ or ACC_WRITE; a write takes priority when both strobes are low. ACC_READ captures the read snapshot and ACC_WRITE commits the byte. Each of these lasts exactly one cycle and then moves to ACC_WAIT, which returns to ACC_IDLE once chip select or both strobes are released.

Bus lines enter and leave the block in active-low form. Every output enable is active high, meaning "pull the line low".

Top module: `pbus_host_regfile`

## Requirements
- R1: After the active-low reset, every writable register reads zero, `ctl_drv`, `db_oe`, `irq`, `rdata_oe` and all start strobes are 0, and `mode_out` and `sel_id` are zero.
- R2: A read seen in ACC_IDLE raises `rdata_oe` on the second rising edge after the strobe is first sampled. The captured byte stays stable on `rdata` until the edge after chip select or the strobe is released, when `rdata_oe` falls. One strobe assertion causes exactly one access.
- R3: Writing location 0 loads the output byte. `db_oe` is high only while command bit 0 is set. `db_out_n` is the complement of the byte, and `dbp_out_n` is the active-low odd-parity bit of the byte.
- R4: Command register (location 1) bits 7, 4, 3, 2 and 1 enable the drivers `ctl_drv[8]` (RST), `ctl_drv[4]` (ACK), `ctl_drv[7]` (BSY), `ctl_drv[6]` (SEL) and `ctl_drv[5]` (ATN). Bit 5 is not stored. A read returns bit 7, then `core_stat[0]` (arbitration in progress) in bit 6, then `core_stat[1]` (arbitration lost) in bit 5, then stored bits 4..0.
- R5: While command bit 6 is set, every driver enable (`ctl_drv` and `db_oe`) is released.
- R6: Location 2 is a read/write mode byte exported on `mode_out`. Bit 6 is target mode, bit 5 is parity check enable and bit 4 is parity interrupt enable.
- R7: Location 3 bits 3..0 enable `ctl_drv[3]` (REQ), `ctl_drv[2]` (MSG), `ctl_drv[1]` (C/D) and `ctl_drv[0]` (I/O), only while mode bit 6 is set. A read returns `core_stat[2]` (last byte sent) in bit 7, zeros in bits 6..4, and the stored bits 3..0.
- R8: Writing location 4 loads `sel_id`. Reading it returns the active-high live bus lines RST, BSY, REQ, MSG, C/D, I/O, SEL and parity, from bit 7 down to bit 0.
- R9: Reading location 5 returns, from bit 7 down, `core_stat[3]` (end DMA), `core_stat[4]` (DMA request), parity error, IRQ, `core_stat[5]` (phase match), `core_stat[6]` (bus error), live ATN and live ACK.
- R10: The input byte is latched as the complement of `db_in_n` on the edge where REQ becomes active (initiator) or ACK becomes active (target). Reading location 6 returns the latched byte.
- R11: With mode bit 5 set, a latch or a read of location 0 whose 8 data bits plus parity bit hold an even count of ones sets the parity error flag. `irq` rises if mode bit 4 is also set. A RST line becoming active also raises `irq`.
- R12: Reading location 7 returns 0 and clears both the parity error flag and `irq`. Writes to locations 5, 6 and 7 each pulse `start_send`, `start_trx` and `start_irx` respectively for exactly one cycle.
- R13: Reading location 0 returns the complement of the live `db_in_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register location |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte |
| rdata_oe | output | 1 | Read data valid / drive enable |
| db_in_n | input | 8 | Bus data lines, active low |
| dbp_in_n | input | 1 | Bus parity line, active low |
| ctl_in_n | input | 9 | Bus control lines, active low: 0 I/O, 1 C/D, 2 MSG, 3 REQ, 4 ACK, 5 ATN, 6 SEL, 7 BSY, 8 RST |
| core_stat | input | 7 | Controller status flags, indices as in R4, R7, R9 |
| ctl_drv | output | 9 | Control line pull enables, same indices as ctl_in_n |
| db_oe | output | 1 | Data line driver enable |
| db_out_n | output | 8 | Outgoing data, active low |
| dbp_out_n | output | 1 | Outgoing odd parity, active low |
| mode_out | output | 8 | Mode byte |
| sel_id | output | 8 | Select-ID byte |
| start_send | output | 1 | DMA send start strobe |
| start_trx | output | 1 | DMA target receive start strobe |
| start_irx | output | 1 | DMA initiator receive start strobe |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every input is already synchronous to `clk`. They also assume that the address and write byte stay steady from the strobe edge until ACC_WAIT, and that `rd_n` is released only by the host that asserted it. The stimulus changes inputs only on falling clock edges. It holds the address and data through each whole access and separates accesses by idle cycles, so every strobe is seen in ACC_IDLE. Bus lines and status flags are changed only between accesses, so each read snapshot has one defined value.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
    localparam int DW     = 8;
    localparam int AW     = 3;
    localparam int CTL_N  = 9;
    localparam int STAT_N = 7;
    localparam int TPH_N  = 4;

    typedef logic [DW-1:0] byte_t;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_WAIT  = 2'd3
    } acc_state_t;

    localparam logic [AW-1:0] ADR_DATA  = 3'd0;
    localparam logic [AW-1:0] ADR_ICMD  = 3'd1;
    localparam logic [AW-1:0] ADR_MODE  = 3'd2;
    localparam logic [AW-1:0] ADR_TCMD  = 3'd3;
    localparam logic [AW-1:0] ADR_BUS   = 3'd4;
    localparam logic [AW-1:0] ADR_STAT  = 3'd5;
    localparam logic [AW-1:0] ADR_INDAT = 3'd6;
    localparam logic [AW-1:0] ADR_CLEAR = 3'd7;

    localparam int CTL_IO  = 0;
    localparam int CTL_CD  = 1;
    localparam int CTL_MSG = 2;
    localparam int CTL_REQ = 3;
    localparam int CTL_ACK = 4;
    localparam int CTL_ATN = 5;
    localparam int CTL_SEL = 6;
    localparam int CTL_BSY = 7;
    localparam int CTL_RST = 8;

    localparam int ST_ARB_BUSY = 0;
    localparam int ST_ARB_LOST = 1;
    localparam int ST_LAST     = 2;
    localparam int ST_END_DMA  = 3;
    localparam int ST_DMA_REQ  = 4;
    localparam int ST_PH_MATCH = 5;
    localparam int ST_BUS_ERR  = 6;

    localparam int MD_TARGET  = 6;
    localparam int MD_PAR_CHK = 5;
    localparam int MD_PAR_IRQ = 4;

    localparam int IC_RST  = 7;
    localparam int IC_TRI  = 6;
    localparam int IC_RSVD = 5;
    localparam int IC_ACK  = 4;
    localparam int IC_BSY  = 3;
    localparam int IC_SEL  = 2;
    localparam int IC_ATN  = 1;
    localparam int IC_DATA = 0;
endpackage

// File: rtl/pbus_access_fsm.sv
module pbus_access_fsm
    import pbus_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  byte_t         wdata,
    output logic [AW-1:0] addr_q,
    output byte_t         wdata_q,
    output logic          rd_pulse,
    output logic          wr_pulse,
    output logic          rd_hold
);
    acc_state_t state_q, state_d;
    logic       sel_wr, sel_rd, released;

    assign sel_wr   = !cs_n && !wr_n;
    assign sel_rd   = !cs_n && !rd_n;
    assign released = cs_n || (rd_n && wr_n);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: begin
                if (sel_wr)      state_d = ACC_WRITE;
                else if (sel_rd) state_d = ACC_READ;
            end
            ACC_READ:  state_d = ACC_WAIT;
            ACC_WRITE: state_d = ACC_WAIT;
            ACC_WAIT:  if (released) state_d = ACC_IDLE;
        endcase
    end

    // outputs
    assign rd_pulse = (state_q == ACC_READ);
    assign wr_pulse = (state_q == ACC_WRITE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rd_hold <= 1'b0;
        end else begin
            if (state_q == ACC_IDLE && (sel_wr || sel_rd)) begin
                addr_q  <= addr;
                wdata_q <= wdata;
            end
            if (state_q == ACC_READ)       rd_hold <= 1'b1;
            else if (state_d == ACC_IDLE)  rd_hold <= 1'b0;
        end
    end
endmodule

// File: rtl/pbus_regbank.sv
module pbus_regbank
    import pbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_pulse,
    input  logic [AW-1:0]    addr_q,
    input  byte_t            wdata_q,
    output byte_t            out_data,
    output byte_t            icmd,
    output byte_t            mode,
    output logic [TPH_N-1:0] tcmd,
    output byte_t            sel_id,
    output logic             start_send,
    output logic             start_trx,
    output logic             start_irx,
    output logic [CTL_N-1:0] ctl_drv,
    output logic             db_oe,
    output byte_t            db_out_n,
    output logic             dbp_out_n
);
    logic [CTL_N-1:0] drv_raw;
    logic             tri_test;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data   <= '0;
            icmd       <= '0;
            mode       <= '0;
            tcmd       <= '0;
            sel_id     <= '0;
            start_send <= 1'b0;
            start_trx  <= 1'b0;
            start_irx  <= 1'b0;
        end else begin
            start_send <= wr_pulse && (addr_q == ADR_STAT);
            start_trx  <= wr_pulse && (addr_q == ADR_INDAT);
            start_irx  <= wr_pulse && (addr_q == ADR_CLEAR);
            if (wr_pulse) begin
                unique case (addr_q)
                    ADR_DATA: out_data <= wdata_q;
                    ADR_ICMD: begin
                        icmd          <= wdata_q;
                        icmd[IC_RSVD] <= 1'b0;
                    end
                    ADR_MODE: mode   <= wdata_q;
                    ADR_TCMD: tcmd   <= wdata_q[TPH_N-1:0];
                    ADR_BUS:  sel_id <= wdata_q;
                    default: ;
                endcase
            end
        end
    end

    // initiator-owned lines
    assign drv_raw[CTL_RST] = icmd[IC_RST];
    assign drv_raw[CTL_BSY] = icmd[IC_BSY];
    assign drv_raw[CTL_SEL] = icmd[IC_SEL];
    assign drv_raw[CTL_ATN] = icmd[IC_ATN];
    assign drv_raw[CTL_ACK] = icmd[IC_ACK];

    // target phase lines, gated by target mode
    for (genvar i = 0; i < TPH_N; i++) begin : g_tph
        assign drv_raw[CTL_IO + i] = tcmd[i] && mode[MD_TARGET];
    end

    assign tri_test  = icmd[IC_TRI];
    assign ctl_drv   = tri_test ? '0 : drv_raw;
    assign db_oe     = icmd[IC_DATA] && !tri_test;
    assign db_out_n  = ~out_data;
    assign dbp_out_n = ^out_data;
endmodule

// File: rtl/pbus_latch_irq.sv
module pbus_latch_irq
    import pbus_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  byte_t db_in_n,
    input  logic  dbp_in_n,
    input  logic  req_n,
    input  logic  ack_n,
    input  logic  brst_n,
    input  logic  target,
    input  logic  par_chk_en,
    input  logic  par_irq_en,
    input  logic  rd_data_pulse,
    input  logic  clr_pulse,
    output byte_t in_data,
    output logic  par_err,
    output logic  irq
);
    logic  req_prev, ack_prev, brst_prev;
    logic  hs_edge, brst_edge, bad_par, par_event;
    byte_t live;

    assign live      = ~db_in_n;
    assign bad_par   = !(^{live, !dbp_in_n});
    assign hs_edge   = target ? (!ack_n && !ack_prev) : (!req_n && !req_prev);
    assign brst_edge = !brst_n && !brst_prev;
    assign par_event = par_chk_en && bad_par && (hs_edge || rd_data_pulse);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_prev  <= 1'b0;
            ack_prev  <= 1'b0;
            brst_prev <= 1'b0;
            in_data   <= '0;
            par_err   <= 1'b0;
            irq       <= 1'b0;
        end else begin
            req_prev  <= !req_n;
            ack_prev  <= !ack_n;
            brst_prev <= !brst_n;
            if (hs_edge) in_data <= live;
            if (par_event)      par_err <= 1'b1;
            else if (clr_pulse) par_err <= 1'b0;
            if ((par_event && par_irq_en) || brst_edge) irq <= 1'b1;
            else if (clr_pulse)                          irq <= 1'b0;
        end
    end
endmodule

// File: rtl/pbus_host_regfile.sv
module pbus_host_regfile
    import pbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [2:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              rdata_oe,
    input  logic [7:0]        db_in_n,
    input  logic              dbp_in_n,
    input  logic [8:0]        ctl_in_n,
    input  logic [6:0]        core_stat,
    output logic [8:0]        ctl_drv,
    output logic              db_oe,
    output logic [7:0]        db_out_n,
    output logic              dbp_out_n,
    output logic [7:0]        mode_out,
    output logic [7:0]        sel_id,
    output logic              start_send,
    output logic              start_trx,
    output logic              start_irx,
    output logic              irq
);
    logic [AW-1:0]    addr_q;
    byte_t            wdata_q, out_data, icmd, mode, in_data, rd_mux, rdata_q;
    logic [TPH_N-1:0] tcmd;
    logic             rd_pulse, wr_pulse, rd_hold, par_err;
    logic [CTL_N-1:0] bus;

    pbus_access_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .addr_q(addr_q), .wdata_q(wdata_q),
        .rd_pulse(rd_pulse), .wr_pulse(wr_pulse), .rd_hold(rd_hold)
    );

    pbus_regbank u_regs (
        .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .addr_q(addr_q),
        .wdata_q(wdata_q), .out_data(out_data), .icmd(icmd), .mode(mode),
        .tcmd(tcmd), .sel_id(sel_id), .start_send(start_send),
        .start_trx(start_trx), .start_irx(start_irx), .ctl_drv(ctl_drv),
        .db_oe(db_oe), .db_out_n(db_out_n), .dbp_out_n(dbp_out_n)
    );

    pbus_latch_irq u_lirq (
        .clk(clk), .rst_n(rst_n), .db_in_n(db_in_n), .dbp_in_n(dbp_in_n),
        .req_n(ctl_in_n[CTL_REQ]), .ack_n(ctl_in_n[CTL_ACK]),
        .brst_n(ctl_in_n[CTL_RST]), .target(mode[MD_TARGET]),
        .par_chk_en(mode[MD_PAR_CHK]), .par_irq_en(mode[MD_PAR_IRQ]),
        .rd_data_pulse(rd_pulse && (addr_q == ADR_DATA)),
        .clr_pulse(rd_pulse && (addr_q == ADR_CLEAR)),
        .in_data(in_data), .par_err(par_err), .irq(irq)
    );

    assign bus = ~ctl_in_n;

    always_comb begin
        rd_mux = '0;
        unique case (addr_q)
            ADR_DATA:  rd_mux = ~db_in_n;
            ADR_ICMD:  rd_mux = {icmd[IC_RST], core_stat[ST_ARB_BUSY],
                                 core_stat[ST_ARB_LOST], icmd[IC_ACK],
                                 icmd[IC_BSY], icmd[IC_SEL], icmd[IC_ATN],
                                 icmd[IC_DATA]};
            ADR_MODE:  rd_mux = mode;
            ADR_TCMD:  rd_mux = {core_stat[ST_LAST], 3'b000, tcmd};
            ADR_BUS:   rd_mux = {bus[CTL_RST], bus[CTL_BSY], bus[CTL_REQ],
                                 bus[CTL_MSG], bus[CTL_CD], bus[CTL_IO],
                                 bus[CTL_SEL], !dbp_in_n};
            ADR_STAT:  rd_mux = {core_stat[ST_END_DMA], core_stat[ST_DMA_REQ],
                                 par_err, irq, core_stat[ST_PH_MATCH],
                                 core_stat[ST_BUS_ERR], bus[CTL_ATN],
                                 bus[CTL_ACK]};
            ADR_INDAT: rd_mux = in_data;
            ADR_CLEAR: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rdata_q <= '0;
        else if (rd_pulse) rdata_q <= rd_mux;
    end

    assign rdata    = rdata_q;
    assign rdata_oe = rd_hold;
    assign mode_out = mode;
endmodule

// File: rtl/pbus_host_regfile_chk.sv
module pbus_host_regfile_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       rd_n,
    input logic [7:0] rdata,
    input logic       rdata_oe,
    input logic [8:0] ctl_in_n,
    input logic [8:0] ctl_drv,
    input logic [7:0] mode_out,
    input logic       start_send,
    input logic       start_trx,
    input logic       start_irx,
    input logic       irq
);
    assert_rdata_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_oe && $past(rdata_oe)) |-> $stable(rdata));

    assert_oe_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> $past(!cs_n && !rd_n));

    assert_phase_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_out[6] |-> (ctl_drv[3:0] == 4'b0000));

    assert_start_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_send, start_trx, start_irx}));

    assert_start_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (start_send || start_trx || start_irx) |=> !(start_send || start_trx || start_irx));

    assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(!ctl_in_n[8]) || $past(mode_out[4])));
endmodule

bind pbus_host_regfile pbus_host_regfile_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .rdata(rdata),
    .rdata_oe(rdata_oe), .ctl_in_n(ctl_in_n), .ctl_drv(ctl_drv),
    .mode_out(mode_out), .start_send(start_send), .start_trx(start_trx),
    .start_irx(start_irx), .irq(irq)
);

// File: tb/pbus_host_regfile_tb.sv
module pbus_host_regfile_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rdata_oe;
    logic [7:0] db_in_n = 8'hFF;
    logic       dbp_in_n = 1'b1;
    logic [8:0] ctl_in_n = 9'h1FF;
    logic [6:0] core_stat = '0;
    logic [8:0] ctl_drv;
    logic       db_oe, dbp_out_n, start_send, start_trx, start_irx, irq;
    logic [7:0] db_out_n, mode_out, sel_id;

    int checks = 0, failures = 0;
    int n_send = 0, n_trx = 0, n_irx = 0;
    bit done = 0;
    logic oe_prev = 1'b0;
    logic [7:0] q_val[$];
    string      q_tag[$];

    always #10 clk = ~clk;

    pbus_host_regfile u_dut (.*);

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    initial forever begin
        @(negedge clk);
        if (rdata_oe && !oe_prev) begin
            checks++;
            if (q_val.size() == 0) begin
                failures++;
                $display("FAIL unexpected read actual=%h expected=none", rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = q_val.pop_front();
                t = q_tag.pop_front();
                if (rdata !== e) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", t, rdata, e);
                end
            end
        end
        oe_prev = rdata_oe;
        if (start_send) n_send++;
        if (start_trx)  n_trx++;
        if (start_irx)  n_irx++;
    end

    task automatic host_write(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
        repeat (3) @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic host_read(logic [2:0] a, logic [7:0] e, string tag);
        q_val.push_back(e);
        q_tag.push_back(tag);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        repeat (3) @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_req();
        @(negedge clk); ctl_in_n[3] = 1'b0;
        repeat (2) @(negedge clk); ctl_in_n[3] = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctl_drv", 16'(ctl_drv), 16'h0);
        chk("R1 db_oe", 16'(db_oe), 16'h0);
        chk("R1 irq", 16'(irq), 16'h0);
        chk("R1 rdata_oe", 16'(rdata_oe), 16'h0);
        chk("R1 mode_out", 16'(mode_out), 16'h0);
        chk("R1 sel_id", 16'(sel_id), 16'h0);
        host_read(3'd1, 8'h00, "R1 icmd read");
        host_read(3'd2, 8'h00, "R1 mode read");
        host_read(3'd3, 8'h00, "R1 tcmd read");

        // R13 live data read
        db_in_n = 8'hC3; dbp_in_n = 1'b0;
        host_read(3'd0, 8'h3C, "R13 live data");

        // R2 extended read timing
        q_val.push_back(8'h3C); q_tag.push_back("R2 held read");
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; addr = 3'd0;
        @(negedge clk); chk("R2 oe not yet", 16'(rdata_oe), 16'h0);
        @(negedge clk); chk("R2 oe up", 16'(rdata_oe), 16'h1);
        repeat (5) @(negedge clk);
        chk("R2 oe held", 16'(rdata_oe), 16'h1);
        chk("R2 data held", 16'(rdata), 16'h3C);
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk); chk("R2 oe drop", 16'(rdata_oe), 16'h0);
        @(negedge clk);

        // R3 output data
        host_write(3'd0, 8'h5A);
        chk("R3 oe off", 16'(db_oe), 16'h0);
        host_write(3'd1, 8'h01);
        chk("R3 oe on", 16'(db_oe), 16'h1);
        chk("R3 db_out_n", 16'(db_out_n), 16'hA5);
        chk("R3 parity", 16'(dbp_out_n), 16'h0);

        // R4 command bits
        host_write(3'd1, 8'h9F);
        chk("R4 ctl_drv", 16'(ctl_drv), 16'h1F0);
        core_stat = 7'h01;
        host_read(3'd1, 8'hDF, "R4 icmd read");
        core_stat = 7'h00;

        // R5 tri-state test
        host_write(3'd1, 8'hFF);
        chk("R5 ctl released", 16'(ctl_drv), 16'h0);
        chk("R5 db released", 16'(db_oe), 16'h0);
        host_read(3'd1, 8'h9F, "R5 icmd read");
        host_write(3'd1, 8'h00);

        // R6 mode
        host_write(3'd2, 8'hA5);
        chk("R6 mode_out", 16'(mode_out), 16'hA5);
        host_read(3'd2, 8'hA5, "R6 mode read");

        // R7 target phase
        host_write(3'd2, 8'h00);
        host_write(3'd3, 8'h0F);
        chk("R7 gated", 16'(ctl_drv), 16'h000);
        host_write(3'd2, 8'h40);
        chk("R7 driven", 16'(ctl_drv), 16'h00F);
        core_stat = 7'h04;
        host_read(3'd3, 8'h8F, "R7 tcmd read");
        core_stat = 7'h00;
        host_write(3'd3, 8'h00);

        // R8 select id and live bus
        host_write(3'd4, 8'h24);
        chk("R8 sel_id", 16'(sel_id), 16'h24);
        ctl_in_n = 9'h13E; dbp_in_n = 1'b0;
        host_read(3'd4, 8'h47, "R8 bus read");
        ctl_in_n = 9'h1FF;

        // R9 status
        core_stat = 7'h28; ctl_in_n[5] = 1'b0;
        host_read(3'd5, 8'h8A, "R9 status read");
        core_stat = 7'h00; ctl_in_n = 9'h1FF;

        // R10 input latch, good parity
        host_write(3'd2, 8'h30);
        db_in_n = 8'hA5; dbp_in_n = 1'b0;
        pulse_req();
        db_in_n = 8'hFF;
        host_read(3'd6, 8'h5A, "R10 latched data");
        chk("R11 no irq good parity", 16'(irq), 16'h0);
        host_read(3'd5, 8'h00, "R11 no error");

        // R11 bad parity on handshake
        db_in_n = 8'hA5; dbp_in_n = 1'b1;
        pulse_req();
        chk("R11 irq on parity", 16'(irq), 16'h1);
        host_read(3'd5, 8'h30, "R11 error status");

        // R12 clear
        host_read(3'd7, 8'h00, "R12 clear read");
        chk("R12 irq cleared", 16'(irq), 16'h0);
        host_read(3'd5, 8'h00, "R12 status cleared");

        // R11 parity on data read
        host_read(3'd0, 8'h5A, "R13 data read bad parity");
        host_read(3'd5, 8'h30, "R11 read parity error");
        host_read(3'd7, 8'h00, "R12 clear again");
        dbp_in_n = 1'b0;

        // R11 bus reset interrupt
        host_write(3'd2, 8'h00);
        @(negedge clk); ctl_in_n[8] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 irq on bus rst", 16'(irq), 16'h1);
        ctl_in_n[8] = 1'b1;
        host_read(3'd7, 8'h00, "R12 clear rst irq");
        chk("R12 irq cleared after rst", 16'(irq), 16'h0);

        // R12 start strobes
        n_send = 0; n_trx = 0; n_irx = 0;
        host_write(3'd5, 8'h00);
        host_write(3'd6, 8'h00);
        host_write(3'd7, 8'h00);
        chk("R12 send strobe", 16'(n_send), 16'h1);
        chk("R12 trx strobe", 16'(n_trx), 16'h1);
        chk("R12 irx strobe", 16'(n_irx), 16'h1);

        repeat (4) @(negedge clk);
        chk("R2 all reads seen", 16'(q_val.size()), 16'h0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule